// File: doc/BRIEF.md
# Two-Chain Delay Model Builder and Response Predictor

This block characterises a delay-based physically unclonable function whose two signal chains never cross. It drives challenges to the function and asks an external timing instrument for the total delay through each chain. From those answers it builds a linear delay model: a base delay per chain, plus one signed contribution per stage that a challenge bit of 1 adds to that chain. It then predicts the response bit for any challenge without measuring it.

The sweep always starts from the all-zero challenge, which gives the base terms. It then applies each single-bit challenge, lowest stage first, and ends with the all-zero challenge again. The last measurement is used only as a drift check against the first one, with a threshold that software supplies. A prediction request is served one cycle later. Until a sweep has completed, a request returns an invalid status.

Top module: `puf_delay_char`

## Requirements
- R1: After reset, `meas_req_o`, `busy_o`, `done_o`, `drift_o` and `pred_valid_o` are 0 and `chal_o` is all zeros.
- R2: A pulse on `start_i` while idle or done starts a sweep of N+2 requests. Request 0 and request N+1 carry challenge 0. Request k, for 1 ≤ k ≤ N, carries only bit k-1 set (bit i selects stage i).
- R3: While `meas_req_o` is 1 and `meas_ack_i` is 0, `chal_o` keeps its value and the request stays raised.
- R4: A cycle in which `meas_ack_i` is sampled with `meas_req_o` high captures both delays, and `meas_req_o` is 0 in the following cycle.
- R5: The first all-zero measurement of each chain is that chain's base delay. The contribution of stage i is that chain's measurement for the bit-i challenge minus its base delay.
- R6: Each chain's modelled delay is its base plus the contributions of the stages whose challenge bit is 1. `pred_resp_o` is 1 only when the top-chain delay minus the bottom-chain delay is greater than zero. A zero difference gives 0.
- R7: `pred_valid_o` is 1 exactly in the cycle after a cycle with `pred_req_i` high.
- R8: A request made before a sweep has completed (since reset, or since the latest start) gives `pred_err_o` = 1 and `pred_resp_o` = 0. After completion `pred_err_o` is 0.
- R9: `drift_o` is set at completion when, for either chain, the absolute difference between the closing and opening all-zero measurements exceeds `drift_thr_i` (unsigned). A difference exactly equal to the threshold does not set it. A new start clears it.
- R10: `busy_o` is 1 from the cycle after an accepted start until the final acknowledge. `done_o` rises in the cycle after that acknowledge. A new start clears `done_o`.
- R11: Measurements anywhere in the full signed input range give the correct prediction, including when every stage is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a characterisation sweep |
| drift_thr_i | input | DW | Allowed difference between the two all-zero measurements |
| chal_o | output | N | Challenge applied to the function |
| meas_req_o | output | 1 | Measurement request |
| meas_ack_i | input | 1 | Measurement done, delays valid |
| meas_top_i | input | DW | Signed total delay of the top chain |
| meas_bot_i | input | DW | Signed total delay of the bottom chain |
| pred_req_i | input | 1 | Prediction request |
| pred_chal_i | input | N | Challenge to predict |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_resp_o | output | 1 | Predicted response bit |
| pred_err_o | output | 1 | Model not ready, result invalid |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Model complete |
| drift_o | output | 1 | Reference drift beyond threshold |

## Verification
The bench delays each acknowledge by a random number of cycles. A design that let the challenge move or dropped the request early would show a changed `chal_o` before the acknowledge. One that skipped the idle cycle after an acknowledge would show a high request in that cycle. Drift is tried one step above the threshold, exactly at it, and in both directions. An off-by-one comparison, or one that looked at only one chain, gives the wrong flag. Predictions cover a tie between the two chains, where a design that treats zero as positive answers 1. They also cover full-scale inputs with every stage selected, where a narrow accumulator wraps and flips the sign. Requests made before completion and just after a restart catch a design that serves a stale or half-built model.

// File: rtl/puf_char_pkg.sv
// Shared types for the delay-model characterisation block.
// Assumes: nothing beyond IEEE 1800-2017.
package puf_char_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ASK  = 2'd1,
        SQ_GAP  = 2'd2,
        SQ_DONE = 2'd3
    } sq_state_e;
endpackage

// File: rtl/puf_char_seq.sv
// Sweep sequencer: issues N+2 measurement requests (zero challenge, each
// single-bit challenge from stage 0 up, zero challenge again), holds each
// challenge until acknowledged, and leaves one idle cycle between requests.
// Assumes: the acknowledge is only meaningful while the request is raised.
module puf_char_seq
    import puf_char_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          meas_ack_i,
    output logic          meas_req_o,
    output logic [N-1:0]  chal_o,
    output logic          cap_o,
    output logic [IW-1:0] cap_idx_o,
    output logic          start_ok_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam logic [IW-1:0] LAST = IW'(N + 1);

    sq_state_e     state;
    logic [IW-1:0] idx;

    // State and request index progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SQ_IDLE, SQ_DONE: begin
                    if (start_i) begin
                        state <= SQ_ASK;
                        idx   <= '0;
                    end
                end
                SQ_ASK: begin
                    if (meas_ack_i) begin
                        state <= (idx == LAST) ? SQ_DONE : SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    idx   <= idx + 1'b1;
                    state <= SQ_ASK;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Challenge decode: index 0 and N+1 give zero, index k sets bit k-1.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            chal_o[i] = (idx == IW'(i + 1));
        end
    end

    assign meas_req_o = (state == SQ_ASK);
    assign cap_o      = (state == SQ_ASK) && meas_ack_i;
    assign cap_idx_o  = idx;
    assign start_ok_o = start_i && ((state == SQ_IDLE) || (state == SQ_DONE));
    assign busy_o     = (state == SQ_ASK) || (state == SQ_GAP);
    assign done_o     = (state == SQ_DONE);

    // R3: challenge and request held while waiting for the acknowledge.
    p_chal_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req_o && !meas_ack_i) |=> ($stable(chal_o) && meas_req_o));

    // R4: an accepted acknowledge drops the request for a cycle.
    p_gap_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req_o && meas_ack_i) |=> !meas_req_o);

    // R2: at most one challenge bit set during a request.
    p_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |-> $onehot0(chal_o));

    // R10: completion only follows an acknowledge.
    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(meas_ack_i));
endmodule

// File: rtl/puf_char_store.sv
// Model storage: base delay per chain from the opening zero measurement,
// one signed stage contribution per chain from each single-bit measurement,
// and the drift flag from the closing zero measurement.
// Assumes: capture strobes arrive in the sequencer's order, index 0 first.
module puf_char_store #(
    parameter int N  = 8,
    parameter int DW = 16,
    parameter int IW = 4,
    parameter int CW = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_i,
    input  logic [IW-1:0]        cap_idx_i,
    input  logic                 start_ok_i,
    input  logic signed [DW-1:0] meas_top_i,
    input  logic signed [DW-1:0] meas_bot_i,
    input  logic [DW-1:0]        thr_i,
    output logic signed [DW-1:0] base_top_o,
    output logic signed [DW-1:0] base_bot_o,
    output logic [N*CW-1:0]      coef_top_o,
    output logic [N*CW-1:0]      coef_bot_o,
    output logic                 drift_o
);
    logic signed [CW-1:0] dt_top, dt_bot;
    logic [CW-1:0]        abs_top, abs_bot;

    // Difference of the incoming measurement from the stored base.
    always_comb begin
        dt_top  = CW'(meas_top_i) - CW'(base_top_o);
        dt_bot  = CW'(meas_bot_i) - CW'(base_bot_o);
        abs_top = dt_top[CW-1] ? $unsigned(-dt_top) : $unsigned(dt_top);
        abs_bot = dt_bot[CW-1] ? $unsigned(-dt_bot) : $unsigned(dt_bot);
    end

    // Base delays from the opening zero-challenge measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_top_o <= '0;
            base_bot_o <= '0;
        end else if (cap_i && (cap_idx_i == '0)) begin
            base_top_o <= meas_top_i;
            base_bot_o <= meas_bot_i;
        end
    end

    // One contribution register pair per stage.
    for (genvar g = 0; g < N; g++) begin : g_stage
        logic signed [CW-1:0] ct, cb;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ct <= '0;
                cb <= '0;
            end else if (cap_i && (cap_idx_i == IW'(g + 1))) begin
                ct <= dt_top;
                cb <= dt_bot;
            end
        end
        assign coef_top_o[g*CW +: CW] = ct;
        assign coef_bot_o[g*CW +: CW] = cb;
    end

    // Drift flag from the closing zero-challenge measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drift_o <= 1'b0;
        end else if (start_ok_i) begin
            drift_o <= 1'b0;
        end else if (cap_i && (cap_idx_i == IW'(N + 1))) begin
            drift_o <= (abs_top > CW'(thr_i)) || (abs_bot > CW'(thr_i));
        end
    end

    // R9: the flag only rises on the closing measurement.
    p_drift_on_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drift_o) |-> $past(cap_i && (cap_idx_i == IW'(N + 1))));
endmodule

// File: rtl/puf_char_predict.sv
// Predictor: sums each chain's base and selected stage contributions in
// accumulators wide enough for full-scale inputs, and registers the sign
// of the top-minus-bottom difference one cycle after the request.
// Assumes: ready_i is high only while the stored model is complete.
module puf_char_predict #(
    parameter int N  = 8,
    parameter int DW = 16,
    parameter int CW = 17,
    parameter int SW = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [N-1:0]         chal_i,
    input  logic                 ready_i,
    input  logic signed [DW-1:0] base_top_i,
    input  logic signed [DW-1:0] base_bot_i,
    input  logic [N*CW-1:0]      coef_top_i,
    input  logic [N*CW-1:0]      coef_bot_i,
    output logic                 valid_o,
    output logic                 resp_o,
    output logic                 err_o
);
    logic signed [SW-1:0] term_t [N];
    logic signed [SW-1:0] term_b [N];
    logic signed [SW-1:0] tot_t, tot_b;
    logic signed [SW:0]   diff;
    logic                 pos;

    // Per-stage selected contributions, sign-extended.
    for (genvar g = 0; g < N; g++) begin : g_term
        assign term_t[g] = chal_i[g] ? SW'(signed'(coef_top_i[g*CW +: CW])) : '0;
        assign term_b[g] = chal_i[g] ? SW'(signed'(coef_bot_i[g*CW +: CW])) : '0;
    end

    // Chain totals and their difference.
    always_comb begin
        tot_t = SW'(base_top_i);
        tot_b = SW'(base_bot_i);
        for (int i = 0; i < N; i++) begin
            tot_t = tot_t + term_t[i];
            tot_b = tot_b + term_b[i];
        end
        diff = (SW+1)'(tot_t) - (SW+1)'(tot_b);
        pos  = !diff[SW] && (diff != '0);
    end

    // Registered result, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            resp_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                err_o  <= !ready_i;
                resp_o <= ready_i && pos;
            end
        end
    end

    // R7: a request yields a valid result next cycle.
    p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R7: no result without a request.
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R8: a request before completion reports invalid.
    p_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ready_i) |=> (err_o && !resp_o));
endmodule

// File: rtl/puf_delay_char.sv
// Top level: characterises a two-chain delay function from N+2 measurement
// pairs and predicts its response for arbitrary challenges.
// Assumes: the external instrument returns signed DW-bit chain delays.
module puf_delay_char #(
    parameter int N  = 8,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DW-1:0]        drift_thr_i,
    output logic [N-1:0]         chal_o,
    output logic                 meas_req_o,
    input  logic                 meas_ack_i,
    input  logic signed [DW-1:0] meas_top_i,
    input  logic signed [DW-1:0] meas_bot_i,
    input  logic                 pred_req_i,
    input  logic [N-1:0]         pred_chal_i,
    output logic                 pred_valid_o,
    output logic                 pred_resp_o,
    output logic                 pred_err_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 drift_o
);
    localparam int IW = $clog2(N + 2);
    localparam int CW = DW + 1;
    localparam int SW = DW + 2 + $clog2(N + 1);

    logic                 cap;
    logic [IW-1:0]        cap_idx;
    logic                 start_ok;
    logic signed [DW-1:0] base_top, base_bot;
    logic [N*CW-1:0]      coef_top, coef_bot;

    puf_char_seq #(.N(N), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .meas_ack_i (meas_ack_i),
        .meas_req_o (meas_req_o),
        .chal_o     (chal_o),
        .cap_o      (cap),
        .cap_idx_o  (cap_idx),
        .start_ok_o (start_ok),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    puf_char_store #(.N(N), .DW(DW), .IW(IW), .CW(CW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap),
        .cap_idx_i  (cap_idx),
        .start_ok_i (start_ok),
        .meas_top_i (meas_top_i),
        .meas_bot_i (meas_bot_i),
        .thr_i      (drift_thr_i),
        .base_top_o (base_top),
        .base_bot_o (base_bot),
        .coef_top_o (coef_top),
        .coef_bot_o (coef_bot),
        .drift_o    (drift_o)
    );

    puf_char_predict #(.N(N), .DW(DW), .CW(CW), .SW(SW)) u_pred (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (pred_req_i),
        .chal_i     (pred_chal_i),
        .ready_i    (done_o),
        .base_top_i (base_top),
        .base_bot_i (base_bot),
        .coef_top_i (coef_top),
        .coef_bot_i (coef_bot),
        .valid_o    (pred_valid_o),
        .resp_o     (pred_resp_o),
        .err_o      (pred_err_o)
    );

    // R10: never busy and done at once.
    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
endmodule

// File: tb/puf_delay_char_test.sv
// Bench: random acknowledge latency and random chain delays, plus directed
// drift, tie and full-scale cases; expected values from bench functions.
module puf_delay_char_test;
    localparam int N  = 8;
    localparam int DW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [DW-1:0]        drift_thr_i = '0;
    logic [N-1:0]         chal_o;
    logic                 meas_req_o;
    logic                 meas_ack_i = 1'b0;
    logic signed [DW-1:0] meas_top_i = '0;
    logic signed [DW-1:0] meas_bot_i = '0;
    logic                 pred_req_i = 1'b0;
    logic [N-1:0]         pred_chal_i = '0;
    logic                 pred_valid_o, pred_resp_o, pred_err_o;
    logic                 busy_o, done_o, drift_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    int rt [N+2];
    int rb [N+2];

    always #2.5 clk = ~clk;

    puf_delay_char #(.N(N), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .drift_thr_i(drift_thr_i),
        .chal_o(chal_o), .meas_req_o(meas_req_o), .meas_ack_i(meas_ack_i),
        .meas_top_i(meas_top_i), .meas_bot_i(meas_bot_i),
        .pred_req_i(pred_req_i), .pred_chal_i(pred_chal_i),
        .pred_valid_o(pred_valid_o), .pred_resp_o(pred_resp_o),
        .pred_err_o(pred_err_o), .busy_o(busy_o), .done_o(done_o),
        .drift_o(drift_o)
    );

    task automatic chk(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_chal(int m);
        if (m == 0 || m == N + 1) return '0;
        return N'(1) << (m - 1);
    endfunction

    function automatic int exp_resp(logic [N-1:0] c);
        longint tt = rt[0];
        longint tb = rb[0];
        for (int i = 0; i < N; i++) begin
            if (c[i]) begin
                tt += rt[i+1] - rt[0];
                tb += rb[i+1] - rb[0];
            end
        end
        return (tt - tb > 0) ? 1 : 0;
    endfunction

    function automatic int exp_drift(int thr);
        int dt = rt[N+1] - rt[0];
        int db = rb[N+1] - rb[0];
        if (dt < 0) dt = -dt;
        if (db < 0) db = -db;
        return (dt > thr || db > thr) ? 1 : 0;
    endfunction

    // Run one sweep, answering each request after a random wait.
    task automatic run_char(int thr);
        drift_thr_i = DW'(thr);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R10 busy after start", busy_o, 1);
        chk("R10 done cleared by start", done_o, 0);
        chk("R9 drift cleared by start", drift_o, 0);
        for (int m = 0; m < N + 2; m++) begin
            int guard = 0;
            while (!meas_req_o && guard < 50) begin
                @(negedge clk); guard++;
            end
            chk("R2 request raised", meas_req_o, 1);
            chk("R2 challenge order", chal_o, exp_chal(m));
            for (int w = 0; w < int'($urandom % 4); w++) begin
                @(negedge clk);
                chk("R3 challenge held", chal_o, exp_chal(m));
                chk("R3 request held", meas_req_o, 1);
            end
            meas_top_i = DW'(rt[m]);
            meas_bot_i = DW'(rb[m]);
            meas_ack_i = 1'b1;
            @(negedge clk);
            meas_ack_i = 1'b0;
            chk("R4 request drops after ack", meas_req_o, 0);
        end
        chk("R10 done after final ack", done_o, 1);
        chk("R10 not busy when done", busy_o, 0);
        chk("R9 drift flag", drift_o, exp_drift(thr));
    endtask

    task automatic predict(logic [N-1:0] c, int ready, string tag);
        @(negedge clk);
        pred_req_i = 1'b1;
        pred_chal_i = c;
        @(negedge clk);
        pred_req_i = 1'b0;
        chk("R7 valid next cycle", pred_valid_o, 1);
        chk("R8 error status", pred_err_o, ready ? 0 : 1);
        chk(tag, pred_resp_o, ready ? exp_resp(c) : 0);
        @(negedge clk);
        chk("R7 valid one cycle only", pred_valid_o, 0);
    endtask

    task automatic fill_random();
        rt[0] = 3000 + int'($urandom % 2000) - 1000;
        rb[0] = 3000 + int'($urandom % 2000) - 1000;
        for (int i = 1; i <= N; i++) begin
            rt[i] = rt[0] + int'($urandom % 600) - 300;
            rb[i] = rb[0] + int'($urandom % 600) - 300;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req", meas_req_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 drift", drift_o, 0);
        chk("R1 pred_valid", pred_valid_o, 0);
        chk("R1 chal", chal_o, 0);
        // R8 before any sweep
        predict(8'hA5, 0, "R8 resp before ready");

        // Random models, closing reference within threshold
        for (int r = 0; r < 3; r++) begin
            fill_random();
            rt[N+1] = rt[0] + int'($urandom % 201) - 100;
            rb[N+1] = rb[0] + int'($urandom % 201) - 100;
            run_char(100);
            predict('0, 1, "R5 zero challenge");
            predict('1, 1, "R6 all stages");
            for (int i = 0; i < N; i++) predict(N'(1) << i, 1, "R5 single stage");
            for (int k = 0; k < 20; k++) predict(N'($urandom), 1, "R6 random challenge");
        end

        // R9 one above threshold, top chain positive
        fill_random();
        rt[N+1] = rt[0] + 101; rb[N+1] = rb[0];
        run_char(100);
        // R9 exactly at threshold, bottom chain negative
        rt[N+1] = rt[0]; rb[N+1] = rb[0] - 100;
        run_char(100);
        // R9 one above, bottom chain negative
        rb[N+1] = rb[0] - 101;
        run_char(100);

        // R8 request during a restarted sweep
        fork
            run_char(100);
            begin
                @(negedge clk); @(negedge clk); @(negedge clk);
                pred_req_i = 1'b1; pred_chal_i = 8'h0F;
                @(negedge clk); pred_req_i = 1'b0;
                chk("R8 error during sweep", pred_err_o, 1);
                chk("R8 resp during sweep", pred_resp_o, 0);
            end
        join

        // R6 tie: both chains identical
        for (int m = 0; m < N + 2; m++) begin
            rt[m] = 1234 + m * 7;
            rb[m] = rt[m];
        end
        rt[N+1] = 1234; rb[N+1] = 1234;
        run_char(0);
        predict('0, 1, "R6 tie zero challenge");
        predict(8'h5A, 1, "R6 tie mixed challenge");
        chk("R6 tie gives 0", pred_resp_o, 0);

        // R11 full-scale values
        rt[0] = -32768; rb[0] = 32767;
        for (int i = 1; i <= N; i++) begin rt[i] = 32767; rb[i] = -32768; end
        rt[N+1] = -32768; rb[N+1] = 32767;
        run_char(0);
        predict('1, 1, "R11 full scale all stages");
        predict('0, 1, "R11 full scale zero challenge");
        predict(8'h80, 1, "R11 full scale one stage");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule